// File: doc/BRIEF.md
# Word ALU with Selective Flags

This block is the purely combinational arithmetic and logic unit of a word-only processor that uses two addresses per instruction. Each cycle it takes the destination value (which is also the first source), a second source value and the carry flag as it stands. It returns the new word together with the Minus, Overflow, Zero and Carry flags. A write-enable mask says which of those flags the instruction is allowed to change. Operand fetch, addressing modes, memory and the register file sit outside the block.

An operation is chosen with a mode bit and a 4-bit code. With the mode bit low, the block runs the two-source group: add, subtract, move, and, inclusive or, exclusive or. With the mode bit high, it runs the sixteen single-operand operations that work on the destination value. These include carry materialisation for building multiword sums, absolute value, byte exchange, byte sign extension, shifts, and rotates through the carry.

Top module: `alu16_core`

## Requirements
- R1: With op_mode=0, op_code[2:0] 010..111 select ADD, SUB, MOV, AND, IOR and XOR. Each computes opa op opb; MOV returns opb. op_code[3] has no effect in this mode.
- R2: With op_mode=0 and op_code[2:0] equal to 000 or 001, result equals opa and flag_we is 0000.
- R3: With op_mode=1, code 0000 (CRY) returns cin as 0 or 1. Code 0001 (BRW) returns 0x0000 when cin=0 and 0xFFFF when cin=1.
- R4: Code 0010 (INC) returns opa+1, 0011 (DEC) returns opa-1 and 1001 (NEG) returns 0-opa. Code 1010 (ABS) returns 0-opa when opa[15]=1 and opa otherwise. All wrap modulo 2^16.
- R5: Code 0100 (SWP) exchanges the high and low bytes of opa. Code 0101 (SEX) copies opa[7] into bits 15..8 above opa[7:0].
- R6: Code 0110 (CLR) returns 0x0000, 0111 (SET) returns 0xFFFF and 1000 (INV) returns ~opa.
- R7: Code 1011 (SAR) shifts opa right and keeps bit 15. Code 1101 (SHR) shifts right and fills bit 15 with zero. Code 1100 (SHL) shifts left with zero into bit 0. Carry receives the bit shifted out.
- R8: Code 1110 (ROL) and 1111 (ROR) rotate the 17-bit value {carry, opa}. ROL puts cin in bit 0 and opa[15] in Carry. ROR puts cin in bit 15 and opa[0] in Carry.
- R9: For ADD and INC, Carry is the unsigned carry out of bit 15. For SUB, DEC, NEG and ABS of a negative value, Carry is the borrow, set when the unsigned minuend is below the subtrahend. ABS of a non-negative value clears Carry.
- R10: For add and subtract style operations, Overflow is set when the signed result falls outside -32768..32767. For shifts and rotates, Overflow is set when result bit 15 differs from opa bit 15.
- R11: flag_we uses bit 3=Minus, 2=Overflow, 1=Zero, 0=Carry. It is 1111 for ADD, SUB, INC, DEC, NEG, ABS and all shifts and rotates. It is 1010 for MOV, AND, IOR, XOR, CRY, BRW, SWP, SEX, CLR, SET and INV.
- R12: flags_o uses the same bit order. Minus equals result[15] and Zero is set when result is 0x0000. Every flags_o bit whose flag_we bit is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_mode | input | 1 | 0 selects the two-source group, 1 the single-operand group |
| op_code | input | 4 | Operation code within the selected group |
| opa | input | 16 | Destination and first source value |
| opb | input | 16 | Second source value |
| cin | input | 1 | Current carry flag |
| result | output | 16 | Word to be written to the destination |
| flags_o | output | 4 | New flag values {M, O, Z, C}, masked by flag_we |
| flag_we | output | 4 | Per-flag write enable {M, O, Z, C} |

## Verification
Some properties are checked on every input change by the assertions. These are the legality of the write-enable mask, that unwritten flags read zero, and the pass-through of the reserved two-source codes and of MOV. They also cover the carry and borrow of the shared adder, stated as an unsigned comparison of its operands, and the rotate's use of the incoming carry. The exact result and the Overflow value of every operation can only be shown by the bench scenarios. These include the byte operations, ABS at 0x8000, BRW, and op_code[3] being ignored in two-source mode. The bench compares each of them against a separately written integer model over corner operands and random ones.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    DOP_RSV0 = 3'd0,
    DOP_RSV1 = 3'd1,
    DOP_ADD  = 3'd2,
    DOP_SUB  = 3'd3,
    DOP_MOV  = 3'd4,
    DOP_AND  = 3'd5,
    DOP_IOR  = 3'd6,
    DOP_XOR  = 3'd7
  } dual_op_e;

  typedef enum logic [3:0] {
    SOP_CRY = 4'd0,  SOP_BRW = 4'd1,  SOP_INC = 4'd2,  SOP_DEC = 4'd3,
    SOP_SWP = 4'd4,  SOP_SEX = 4'd5,  SOP_CLR = 4'd6,  SOP_SET = 4'd7,
    SOP_INV = 4'd8,  SOP_NEG = 4'd9,  SOP_ABS = 4'd10, SOP_SAR = 4'd11,
    SOP_SHL = 4'd12, SOP_SHR = 4'd13, SOP_ROL = 4'd14, SOP_ROR = 4'd15
  } single_op_e;

  typedef enum logic [1:0] {
    UNIT_PASS  = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_BITS  = 2'd3
  } unit_e;

  typedef enum logic [2:0] {
    ARI_ADD = 3'd0, ARI_SUB = 3'd1, ARI_INC = 3'd2,
    ARI_DEC = 3'd3, ARI_NEG = 3'd4, ARI_ABS = 3'd5
  } arith_e;

  typedef enum logic [2:0] {
    SHF_SAR = 3'd0, SHF_SHL = 3'd1, SHF_SHR = 3'd2,
    SHF_ROL = 3'd3, SHF_ROR = 3'd4
  } shift_e;

  typedef enum logic [3:0] {
    BIT_MOV = 4'd0, BIT_AND = 4'd1, BIT_IOR = 4'd2, BIT_XOR = 4'd3,
    BIT_CRY = 4'd4, BIT_BRW = 4'd5, BIT_SWP = 4'd6, BIT_SEX = 4'd7,
    BIT_CLR = 4'd8, BIT_SET = 4'd9, BIT_INV = 4'd10
  } bits_e;

  localparam int FLAG_M = 3;
  localparam int FLAG_O = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  localparam logic [3:0] WE_NONE = 4'b0000;
  localparam logic [3:0] WE_MZ   = 4'b1010;
  localparam logic [3:0] WE_ALL  = 4'b1111;

  typedef struct packed {
    unit_e      unit;
    arith_e     ari;
    shift_e     shf;
    bits_e      bsel;
    logic [3:0] we;
  } dec_t;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic       op_mode,
  input  logic [3:0] op_code,
  output dec_t       dec
);

  always_comb begin
    dec.unit = UNIT_PASS;
    dec.ari  = ARI_ADD;
    dec.shf  = SHF_SAR;
    dec.bsel = BIT_MOV;
    dec.we   = WE_NONE;
    if (!op_mode) begin
      case (dual_op_e'(op_code[2:0]))
        DOP_ADD: begin dec.unit = UNIT_ARITH; dec.ari = ARI_ADD; dec.we = WE_ALL; end
        DOP_SUB: begin dec.unit = UNIT_ARITH; dec.ari = ARI_SUB; dec.we = WE_ALL; end
        DOP_MOV: begin dec.unit = UNIT_BITS; dec.bsel = BIT_MOV; dec.we = WE_MZ; end
        DOP_AND: begin dec.unit = UNIT_BITS; dec.bsel = BIT_AND; dec.we = WE_MZ; end
        DOP_IOR: begin dec.unit = UNIT_BITS; dec.bsel = BIT_IOR; dec.we = WE_MZ; end
        DOP_XOR: begin dec.unit = UNIT_BITS; dec.bsel = BIT_XOR; dec.we = WE_MZ; end
        default: begin dec.unit = UNIT_PASS; dec.we = WE_NONE; end
      endcase
    end else begin
      case (single_op_e'(op_code))
        SOP_CRY: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_CRY; dec.we = WE_MZ;  end
        SOP_BRW: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_BRW; dec.we = WE_MZ;  end
        SOP_INC: begin dec.unit = UNIT_ARITH; dec.ari  = ARI_INC; dec.we = WE_ALL; end
        SOP_DEC: begin dec.unit = UNIT_ARITH; dec.ari  = ARI_DEC; dec.we = WE_ALL; end
        SOP_SWP: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_SWP; dec.we = WE_MZ;  end
        SOP_SEX: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_SEX; dec.we = WE_MZ;  end
        SOP_CLR: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_CLR; dec.we = WE_MZ;  end
        SOP_SET: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_SET; dec.we = WE_MZ;  end
        SOP_INV: begin dec.unit = UNIT_BITS;  dec.bsel = BIT_INV; dec.we = WE_MZ;  end
        SOP_NEG: begin dec.unit = UNIT_ARITH; dec.ari  = ARI_NEG; dec.we = WE_ALL; end
        SOP_ABS: begin dec.unit = UNIT_ARITH; dec.ari  = ARI_ABS; dec.we = WE_ALL; end
        SOP_SAR: begin dec.unit = UNIT_SHIFT; dec.shf  = SHF_SAR; dec.we = WE_ALL; end
        SOP_SHL: begin dec.unit = UNIT_SHIFT; dec.shf  = SHF_SHL; dec.we = WE_ALL; end
        SOP_SHR: begin dec.unit = UNIT_SHIFT; dec.shf  = SHF_SHR; dec.we = WE_ALL; end
        SOP_ROL: begin dec.unit = UNIT_SHIFT; dec.shf  = SHF_ROL; dec.we = WE_ALL; end
        default: begin dec.unit = UNIT_SHIFT; dec.shf  = SHF_ROR; dec.we = WE_ALL; end
      endcase
    end
  end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  arith_e       sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] x_op,
  output logic [W-1:0] y_op,
  output logic         sub_mode,
  output logic [W-1:0] sum,
  output logic         cb,
  output logic         ovf
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  // Returns {carry_or_borrow, overflow, sum}
  function automatic logic [W+1:0] add_core(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         sub);
    logic [W-1:0] yy;
    logic [W:0]   t;
    logic         c;
    logic         v;
    yy = sub ? ~y : y;
    t  = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, sub};
    c  = sub ? ~t[W] : t[W];
    if (sub) v = (x[MSB] ^ y[MSB]) & (t[MSB] ^ x[MSB]);
    else     v = ~(x[MSB] ^ y[MSB]) & (t[MSB] ^ x[MSB]);
    return {c, v, t[W-1:0]};
  endfunction

  always_comb begin
    x_op     = a;
    y_op     = b;
    sub_mode = 1'b0;
    case (sel)
      ARI_ADD: begin x_op = a;    y_op = b;   sub_mode = 1'b0; end
      ARI_SUB: begin x_op = a;    y_op = b;   sub_mode = 1'b1; end
      ARI_INC: begin x_op = a;    y_op = ONE; sub_mode = 1'b0; end
      ARI_DEC: begin x_op = a;    y_op = ONE; sub_mode = 1'b1; end
      ARI_NEG: begin x_op = ZERO; y_op = a;   sub_mode = 1'b1; end
      ARI_ABS: begin
        if (a[MSB]) begin x_op = ZERO; y_op = a;    sub_mode = 1'b1; end
        else        begin x_op = a;    y_op = ZERO; sub_mode = 1'b0; end
      end
      default: begin x_op = a; y_op = b; sub_mode = 1'b0; end
    endcase
  end

  logic [W+1:0] packed_out;
  assign packed_out = add_core(x_op, y_op, sub_mode);
  assign sum = packed_out[W-1:0];
  assign ovf = packed_out[W];
  assign cb  = packed_out[W+1];

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  shift_e       sel,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);

  localparam int MSB = W - 1;

  // Returns {bit shifted out, result}
  function automatic logic [W:0] shift_core(input shift_e s,
                                            input logic [W-1:0] v,
                                            input logic c);
    logic [W:0] wide;
    case (s)
      SHF_SAR: wide = {v[0], v[MSB], v[MSB:1]};
      SHF_SHR: wide = {v[0], 1'b0, v[MSB:1]};
      SHF_SHL: wide = {v, 1'b0};
      SHF_ROL: wide = {v, c};
      SHF_ROR: wide = {v[0], c, v[MSB:1]};
      default: wide = {1'b0, v};
    endcase
    return wide;
  endfunction

  logic [W:0] wide_w;
  assign wide_w = shift_core(sel, a, cin);
  assign res    = wide_w[W-1:0];
  assign cout   = wide_w[W];
  assign ovf    = wide_w[MSB] ^ a[MSB];

endmodule

// File: rtl/alu16_bits.sv
module alu16_bits
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  bits_e        sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res
);

  localparam int HALF = W / 2;

  function automatic logic [W-1:0] byte_swap(input logic [W-1:0] v);
    return {v[HALF-1:0], v[W-1:HALF]};
  endfunction

  function automatic logic [W-1:0] byte_sext(input logic [W-1:0] v);
    return {{(W-HALF){v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  always_comb begin
    case (sel)
      BIT_MOV: res = b;
      BIT_AND: res = a & b;
      BIT_IOR: res = a | b;
      BIT_XOR: res = a ^ b;
      BIT_CRY: res = {{(W-1){1'b0}}, cin};
      BIT_BRW: res = {W{cin}};
      BIT_SWP: res = byte_swap(a);
      BIT_SEX: res = byte_sext(a);
      BIT_CLR: res = '0;
      BIT_SET: res = '1;
      BIT_INV: res = ~a;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         op_mode,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic [3:0]   flags_o,
  output logic [3:0]   flag_we
);

  localparam int MSB = W - 1;

  dec_t dec;

  logic [W-1:0] ari_x;
  logic [W-1:0] ari_y;
  logic         ari_sub;
  logic [W-1:0] ari_sum;
  logic         ari_cb;
  logic         ari_ov;

  logic [W-1:0] shf_res;
  logic         shf_out;
  logic         shf_ov;

  logic [W-1:0] bit_res;

  logic [W-1:0] res_w;
  logic         c_raw;
  logic         o_raw;
  logic [3:0]   flags_raw;

  alu16_decode u_dec (
    .op_mode (op_mode),
    .op_code (op_code),
    .dec     (dec)
  );

  alu16_arith #(.W(W)) u_ari (
    .sel      (dec.ari),
    .a        (opa),
    .b        (opb),
    .x_op     (ari_x),
    .y_op     (ari_y),
    .sub_mode (ari_sub),
    .sum      (ari_sum),
    .cb       (ari_cb),
    .ovf      (ari_ov)
  );

  alu16_shift #(.W(W)) u_shf (
    .sel  (dec.shf),
    .a    (opa),
    .cin  (cin),
    .res  (shf_res),
    .cout (shf_out),
    .ovf  (shf_ov)
  );

  alu16_bits #(.W(W)) u_bits (
    .sel (dec.bsel),
    .a   (opa),
    .b   (opb),
    .cin (cin),
    .res (bit_res)
  );

  always_comb begin
    case (dec.unit)
      UNIT_ARITH: begin res_w = ari_sum; c_raw = ari_cb;  o_raw = ari_ov; end
      UNIT_SHIFT: begin res_w = shf_res; c_raw = shf_out; o_raw = shf_ov; end
      UNIT_BITS:  begin res_w = bit_res; c_raw = 1'b0;    o_raw = 1'b0;   end
      default:    begin res_w = opa;     c_raw = 1'b0;    o_raw = 1'b0;   end
    endcase
  end

  always_comb begin
    flags_raw         = '0;
    flags_raw[FLAG_M] = res_w[MSB];
    flags_raw[FLAG_O] = o_raw;
    flags_raw[FLAG_Z] = ~|res_w;
    flags_raw[FLAG_C] = c_raw;
  end

  assign result  = res_w;
  assign flag_we = dec.we;
  assign flags_o = flags_raw & dec.we;

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic         op_mode,
  input logic [3:0]   op_code,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         cin,
  input logic [W-1:0] result,
  input logic [3:0]   flags_o,
  input logic [3:0]   flag_we,
  input logic [W-1:0] ari_x,
  input logic [W-1:0] ari_y,
  input logic         ari_sub,
  input logic         ari_cb
);

  logic known;
  assign known = !$isunknown({op_mode, op_code, opa, opb, cin});

  always_comb begin
    if (known) begin
      // R11
      mask_legal_chk: assert (flag_we == 4'b0000 || flag_we == 4'b1010 || flag_we == 4'b1111)
        else $error("flag write mask %b not legal", flag_we);
      // R12
      masked_zero_chk: assert ((flags_o & ~flag_we) == 4'b0000)
        else $error("unwritten flag reads one: flags %b we %b", flags_o, flag_we);
      // R9
      borrow_chk: assert (!ari_sub || (ari_cb == (ari_x < ari_y)))
        else $error("borrow %b for %h - %h", ari_cb, ari_x, ari_y);
      // R9
      carry_chk: assert (ari_sub || (ari_cb == (ari_x > ~ari_y)))
        else $error("carry %b for %h + %h", ari_cb, ari_x, ari_y);
      // R2
      reserved_pass_chk: assert (op_mode || op_code[2:1] != 2'b00 ||
                                 (result == opa && flag_we == 4'b0000))
        else $error("reserved code altered state");
      // R1
      mov_chk: assert (op_mode || op_code[2:0] != 3'b100 || result == opb)
        else $error("move result %h expected %h", result, opb);
      // R8
      rol_chk: assert (!op_mode || op_code != 4'b1110 ||
                       (result[0] == cin && flags_o[0] == opa[W-1]))
        else $error("rotate left carry path wrong");
    end
  end

endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .op_mode (op_mode),
  .op_code (op_code),
  .opa     (opa),
  .opb     (opb),
  .cin     (cin),
  .result  (result),
  .flags_o (flags_o),
  .flag_we (flag_we),
  .ari_x   (ari_x),
  .ari_y   (ari_y),
  .ari_sub (ari_sub),
  .ari_cb  (ari_cb)
);

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_mode = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [15:0] opa = 16'h0000;
  logic [15:0] opb = 16'h0000;
  logic        cin = 1'b0;
  logic [15:0] result;
  logic [3:0]  flags_o;
  logic [3:0]  flag_we;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  alu16_core #(.W(16)) u0 (
    .op_mode (op_mode),
    .op_code (op_code),
    .opa     (opa),
    .opb     (opb),
    .cin     (cin),
    .result  (result),
    .flags_o (flags_o),
    .flag_we (flag_we)
  );

  typedef struct {
    logic [15:0] res;
    logic [3:0]  flg;
    logic [3:0]  we;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic string op_tag(logic m, logic [3:0] c);
    if (!m) return (c[2:1] == 2'b00) ? "R2" : "R1";
    case (c)
      4'd0, 4'd1:                 return "R3";
      4'd2, 4'd3, 4'd9, 4'd10:    return "R4";
      4'd4, 4'd5:                 return "R5";
      4'd6, 4'd7, 4'd8:           return "R6";
      4'd11, 4'd12, 4'd13:        return "R7";
      default:                    return "R8";
    endcase
  endfunction

  function automatic int to_signed(int u);
    return (u >= 32768) ? u - 65536 : u;
  endfunction

  // Independent integer model of the requirements
  function automatic exp_t model(logic m, logic [3:0] c, logic [15:0] a,
                                 logic [15:0] b, logic ci);
    exp_t e;
    int ua = int'(a);
    int ub = int'(b);
    int uc = ci ? 1 : 0;
    int r = ua;
    int x = 0, y = 0, s, sv;
    bit sub = 0, cy = 0, ov = 0;
    int kind = 0; // 0 none, 1 M/Z, 2 add-sub, 3 shift
    if (!m) begin
      case (c[2:0])
        3'd2: begin kind = 2; x = ua; y = ub; sub = 0; end
        3'd3: begin kind = 2; x = ua; y = ub; sub = 1; end
        3'd4: begin kind = 1; r = ub; end
        3'd5: begin kind = 1; r = ua & ub; end
        3'd6: begin kind = 1; r = ua | ub; end
        3'd7: begin kind = 1; r = ua ^ ub; end
        default: begin kind = 0; r = ua; end
      endcase
    end else begin
      case (c)
        4'd0:  begin kind = 1; r = uc; end
        4'd1:  begin kind = 1; r = ci ? 65535 : 0; end
        4'd2:  begin kind = 2; x = ua; y = 1; sub = 0; end
        4'd3:  begin kind = 2; x = ua; y = 1; sub = 1; end
        4'd4:  begin kind = 1; r = ((ua % 256) * 256) + (ua / 256); end
        4'd5:  begin kind = 1; r = ((ua % 256) >= 128) ? (ua % 256) + 65280 : ua % 256; end
        4'd6:  begin kind = 1; r = 0; end
        4'd7:  begin kind = 1; r = 65535; end
        4'd8:  begin kind = 1; r = 65535 - ua; end
        4'd9:  begin kind = 2; x = 0; y = ua; sub = 1; end
        4'd10: begin
          kind = 2;
          if (ua >= 32768) begin x = 0; y = ua; sub = 1; end
          else begin x = ua; y = 0; sub = 0; end
        end
        4'd11: begin kind = 3; r = (ua / 2) + (ua >= 32768 ? 32768 : 0); cy = ua[0]; end
        4'd12: begin kind = 3; r = (ua * 2) % 65536; cy = ua >= 32768; end
        4'd13: begin kind = 3; r = ua / 2; cy = ua[0]; end
        4'd14: begin kind = 3; r = ((ua * 2) % 65536) + uc; cy = ua >= 32768; end
        default: begin kind = 3; r = (ua / 2) + uc * 32768; cy = ua[0]; end
      endcase
    end
    if (kind == 2) begin
      if (sub) begin
        s = x - y; cy = x < y; sv = to_signed(x) - to_signed(y);
        if (s < 0) s = s + 65536;
      end else begin
        s = x + y; cy = s > 65535; sv = to_signed(x) + to_signed(y);
        s = s % 65536;
      end
      r  = s;
      ov = (sv > 32767) || (sv < -32768);
    end
    if (kind == 3) ov = ((r >= 32768) != (ua >= 32768));
    e.res = r[15:0];
    case (kind)
      0:       e.we = 4'b0000;
      1:       e.we = 4'b1010;
      default: e.we = 4'b1111;
    endcase
    e.flg = {r >= 32768, ov, r == 0, cy} & e.we;
    e.tag = op_tag(m, c);
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic m, logic [3:0] c, logic [15:0] a, logic [15:0] b, logic ci);
    @(negedge clk);
    op_mode = m; op_code = c; opa = a; opb = b; cin = ci;
    exp_q.push_back(model(m, c, a, b, ci));
  endtask

  // Monitor: compares at the rising edge, half a cycle after the drive
  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(result == e.res, e.tag, "result", result, e.res);
      check(flag_we == e.we, "R11", "flag_we", {12'd0, flag_we}, {12'd0, e.we});
      check(flags_o[0] == e.flg[0], "R9", "carry", {15'd0, flags_o[0]}, {15'd0, e.flg[0]});
      check(flags_o[2] == e.flg[2], "R10", "overflow", {15'd0, flags_o[2]}, {15'd0, e.flg[2]});
      check({flags_o[3], flags_o[1]} == {e.flg[3], e.flg[1]}, "R12", "minus/zero",
            {14'd0, flags_o[3], flags_o[1]}, {14'd0, e.flg[3], e.flg[1]});
    end
  end

  logic [15:0] corners [6] = '{16'h0000, 16'h0001, 16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: reserved code with zero operands leaves everything quiet (R2)
    drive(1'b0, 4'd0, 16'h0000, 16'h0000, 1'b0);
    // Named corners
    drive(1'b1, 4'd10, 16'h8000, 16'h0000, 1'b0); // R4 ABS of most negative
    drive(1'b1, 4'd1, 16'h1234, 16'h0000, 1'b1);  // R3 BRW gives all ones
    drive(1'b0, 4'd11, 16'h7FFF, 16'h0001, 1'b0); // R1 op_code[3] ignored: SUB
    drive(1'b0, 4'd2, 16'h7FFF, 16'h0001, 1'b0);  // R10 signed overflow on ADD
    drive(1'b1, 4'd15, 16'h0001, 16'h0000, 1'b1); // R8 ROR through carry
    // Every code in both groups over corner operands, both carry values
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            for (int k = 0; k < 2; k++)
              drive(m[0], c[3:0], corners[i], corners[j], k[0]);
    // Random operands
    for (int n = 0; n < 3000; n++)
      drive(1'($urandom), 4'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule